// File: doc/BRIEF.md
# Staged-Ratio Clock-Enable Divider Bank

This block holds a set of integer dividers that all run from one source clock. Each divider produces a one-cycle enable pulse at a programmable rate. Software writes new ratios into a staging copy. The running dividers ignore these writes until a single commit command loads every pending ratio at the same source-clock edge. A per-output change vector shows which staged ratios differ from the values now running. A mask register picks the outputs whose counters restart at the commit edge, so those outputs pulse together from then on. The remaining outputs keep their phase.

After a commit the block reports busy for a fixed number of cycles. The change vector is wiped when busy drops. While busy is high, further commits and ratio writes are ignored. The register port has no wait states. Writes are single-cycle strobes and reads are combinational from the read address.

Register map (6-bit address). `0x00`: write bit 0 = 1 to commit, read bit 0 = busy. `0x01`: change vector, read-only, bit k for output k. `0x02`: alignment mask, bit k for output k. `0x10+k`: staged ratio of output k. `0x20+k`: running ratio of output k, read-only. Unmapped addresses read as zero.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, every staged and running ratio equals `RST_RATIO` (default 0), the change vector, alignment mask and busy bit read 0, and every divider counter starts at its pulse position.
- R2: With running ratio N on output k, `div_en[k]` is high for one cycle in every N+1 source cycles.
- R3: A write to `0x10+k` (ratio in the low `RATIO_W` bits) updates the staged value read at `0x10+k`. It leaves the running value at `0x20+k` and the pulse train of `div_en[k]` unchanged until a commit.
- R4: Bit k of `0x01` is set by a staged write whose value differs from the running ratio of output k. It is cleared by a staged write whose value equals the running ratio.
- R5: Writing 1 to bit 0 of `0x00` while busy reads 0 loads every flagged staged ratio into its running register at that one clock edge.
- R6: Outputs whose bit is set in `0x02` restart their counters at the commit edge. Each such output pulses in the cycle after that edge, and all of them pulse together there. Each then continues with its new period.
- R7: Outputs whose mask bit is clear and whose ratio is not changed keep their pulse phase across a commit.
- R8: Busy reads 1 for exactly `BUSY_CYC` cycles, starting with the cycle after the commit edge. The change vector clears at the edge where busy falls.
- R9: A commit write while busy reads 1 is ignored, and busy still falls on the schedule of the first commit.
- R10: Ratio writes while busy reads 1 are ignored: the staged value and change vector are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational |
| div_en | output | NUM_OUT | One-cycle enable pulse per divider |

## Verification
The hardest case to reach from the ports is a second commit or a ratio write that lands while an earlier update is still busy. The block must ignore it, but that only shows as the absence of any change. The bench fires a commit and then, inside the busy window, writes a new commit and a different ratio. It then counts source cycles from the first commit to confirm that busy ends exactly on the original schedule, and that the staged value and change vector never moved. Phase keeping on unmasked outputs is checked by extending each output's arithmetic pulse schedule across a commit that restarts only the other outputs.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int ADDR_W = 6;
  localparam int IDX_W  = 4;

  typedef enum logic [1:0] {
    PG_CTRL   = 2'd0,
    PG_STAGE  = 2'd1,
    PG_ACTIVE = 2'd2,
    PG_NONE   = 2'd3
  } page_e;

  localparam logic [IDX_W-1:0] IX_CMD = 4'd0;
  localparam logic [IDX_W-1:0] IX_CHG = 4'd1;
  localparam logic [IDX_W-1:0] IX_ALN = 4'd2;

  function automatic page_e addr_page(input logic [ADDR_W-1:0] a);
    return page_e'(a[ADDR_W-1 -: 2]);
  endfunction

  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

endpackage

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               restart,
  output logic               en
);

  logic [RATIO_W-1:0] cnt_q;

  // next count: wrap to zero once the limit is reached or exceeded
  function automatic logic [RATIO_W-1:0] step(input logic [RATIO_W-1:0] cnt,
                                              input logic [RATIO_W-1:0] lim);
    return (cnt >= lim) ? '0 : cnt + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= step(cnt_q, ratio);
  end

  assign en = (cnt_q == '0);

endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT   = 4,
  parameter int RATIO_W   = 8,
  parameter int DATA_W    = 16,
  parameter int BUSY_CYC  = 6,
  parameter int RST_RATIO = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_OUT*RATIO_W-1:0] active_flat,
  output logic [NUM_OUT*RATIO_W-1:0] staged_flat,
  output logic [NUM_OUT-1:0]         restart,
  output logic [NUM_OUT-1:0]         chg,
  output logic [NUM_OUT-1:0]         aln,
  output logic                       busy,
  output logic                       commit
);

  localparam int BC_W = (BUSY_CYC < 2) ? 1 : $clog2(BUSY_CYC);
  localparam logic [BC_W-1:0] BC_LOAD = BC_W'(BUSY_CYC - 1);
  localparam logic [RATIO_W-1:0] R_INIT = RATIO_W'(RST_RATIO);

  function automatic logic differs(input logic [RATIO_W-1:0] a,
                                   input logic [RATIO_W-1:0] b);
    return a != b;
  endfunction

  page_e            wpg, rpg;
  logic [IDX_W-1:0] widx, ridx;
  logic             go_write, aln_write, busy_done;
  logic [BC_W-1:0]  bcnt_q;
  logic [RATIO_W-1:0] wr_ratio;

  assign wpg      = addr_page(wr_addr);
  assign widx     = addr_index(wr_addr);
  assign rpg      = addr_page(rd_addr);
  assign ridx     = addr_index(rd_addr);
  assign wr_ratio = wr_data[RATIO_W-1:0];

  assign go_write  = wr_en && (wpg == PG_CTRL) && (widx == IX_CMD) && wr_data[0];
  assign aln_write = wr_en && (wpg == PG_CTRL) && (widx == IX_ALN);
  assign commit    = go_write && !busy;
  assign busy_done = busy && (bcnt_q == '0);
  assign restart   = commit ? aln : '0;

  // busy sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      bcnt_q <= '0;
    end else if (commit) begin
      busy   <= 1'b1;
      bcnt_q <= BC_LOAD;
    end else if (busy_done) begin
      busy   <= 1'b0;
    end else if (busy) begin
      bcnt_q <= bcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         aln <= '0;
    else if (aln_write) aln <= wr_data[NUM_OUT-1:0];
  end

  logic [RATIO_W-1:0] staged_q [NUM_OUT];
  logic [RATIO_W-1:0] active_q [NUM_OUT];

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_slot
    logic hit;
    logic chg_q;
    assign hit = wr_en && (wpg == PG_STAGE) && (widx == IDX_W'(k)) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        staged_q[k] <= R_INIT;
        active_q[k] <= R_INIT;
        chg_q       <= 1'b0;
      end else begin
        if (hit) begin
          staged_q[k] <= wr_ratio;
          chg_q       <= differs(wr_ratio, active_q[k]);
        end
        if (commit && chg_q) active_q[k] <= staged_q[k];
        if (busy_done)       chg_q       <= 1'b0;
      end
    end

    assign chg[k] = chg_q;
    assign active_flat[k*RATIO_W +: RATIO_W] = active_q[k];
    assign staged_flat[k*RATIO_W +: RATIO_W] = staged_q[k];
  end

  always_comb begin
    rd_data = '0;
    unique case (rpg)
      PG_CTRL: begin
        if (ridx == IX_CMD) rd_data[0]         = busy;
        if (ridx == IX_CHG) rd_data[NUM_OUT-1:0] = chg;
        if (ridx == IX_ALN) rd_data[NUM_OUT-1:0] = aln;
      end
      PG_STAGE: begin
        for (int k = 0; k < NUM_OUT; k++)
          if (ridx == IDX_W'(k)) rd_data[RATIO_W-1:0] = staged_q[k];
      end
      PG_ACTIVE: begin
        for (int k = 0; k < NUM_OUT; k++)
          if (ridx == IDX_W'(k)) rd_data[RATIO_W-1:0] = active_q[k];
      end
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT   = 4,
  parameter int RATIO_W   = 8,
  parameter int DATA_W    = 16,
  parameter int BUSY_CYC  = 6,
  parameter int RST_RATIO = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_OUT-1:0]  div_en
);

  logic [NUM_OUT*RATIO_W-1:0] active_flat;
  logic [NUM_OUT*RATIO_W-1:0] staged_flat;
  logic [NUM_OUT-1:0]         restart;
  logic [NUM_OUT-1:0]         chg;
  logic [NUM_OUT-1:0]         aln;
  logic                       busy;
  logic                       commit;

  clkdiv_regs #(
    .NUM_OUT(NUM_OUT), .RATIO_W(RATIO_W), .DATA_W(DATA_W),
    .BUSY_CYC(BUSY_CYC), .RST_RATIO(RST_RATIO)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .active_flat(active_flat), .staged_flat(staged_flat),
    .restart(restart), .chg(chg), .aln(aln),
    .busy(busy), .commit(commit)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_div
    clkdiv_counter #(.RATIO_W(RATIO_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .ratio(active_flat[k*RATIO_W +: RATIO_W]),
      .restart(restart[k]),
      .en(div_en[k])
    );
  end

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int NUM_OUT  = 4,
  parameter int RATIO_W  = 8,
  parameter int BUSY_CYC = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       commit,
  input logic [NUM_OUT-1:0]         chg,
  input logic [NUM_OUT-1:0]         aln,
  input logic [NUM_OUT*RATIO_W-1:0] active_flat,
  input logic [NUM_OUT*RATIO_W-1:0] staged_flat,
  input logic [NUM_OUT-1:0]         div_en
);

  logic [15:0]        run_len;
  logic [NUM_OUT-1:0] mism;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_m
    assign mism[k] = staged_flat[k*RATIO_W +: RATIO_W] != active_flat[k*RATIO_W +: RATIO_W];
  end

  AST_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (chg == mism)); // R4

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_flat)); // R3

  AST_ALIGN_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ((div_en & $past(aln)) == $past(aln))); // R6

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 16'(BUSY_CYC))); // R8

  AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < 16'(BUSY_CYC))); // R9

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (chg == '0)); // R8

endmodule

bind clkdiv_bank clkdiv_bank_chk #(
  .NUM_OUT(NUM_OUT), .RATIO_W(RATIO_W), .BUSY_CYC(BUSY_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .commit(commit),
  .chg(chg), .aln(aln), .active_flat(active_flat),
  .staged_flat(staged_flat), .div_en(div_en)
);

// File: tb/test_clkdiv_bank.sv
`timescale 1ns/1ps
module test_clkdiv_bank;

  localparam int NO = 4;
  localparam int RW = 4;
  localparam int DW = 16;
  localparam int BC = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [5:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [5:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [NO-1:0] div_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int t0 [NO];
  int rt [NO];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkdiv_bank #(.NUM_OUT(NO), .RATIO_W(RW), .DATA_W(DW), .BUSY_CYC(BC)) i_clkdiv_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .div_en(div_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d cyc=%0d", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_en(input int k);
    return (((cyc - t0[k]) % (rt[k] + 1)) == 0) ? 1 : 0;
  endfunction

  task automatic rd(input logic [5:0] a, output int v);
    rd_addr = a;
    #0.5;
    v = int'(rd_data);
  endtask

  task automatic wr(input logic [5:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // compare every enable now, then advance one cycle
  task automatic tick(input string req);
    for (int k = 0; k < NO; k++) check(req, int'(div_en[k]), exp_en(k));
    @(negedge clk);
  endtask

  task automatic watch(input string req, input int n);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  task automatic commit_and_wait(input int mask, input int flags);
    int v;
    wr(6'h00, 1);
    for (int k = 0; k < NO; k++) if (mask[k]) t0[k] = cyc;
    for (int i = 0; i < BC; i++) begin
      rd(6'h00, v); check("R8 busy high", v, 1);
      rd(6'h01, v); check("R8 flags held", v, flags);
      tick("R6 aligned pulses");
    end
    rd(6'h00, v); check("R8 busy low", v, 0);
    rd(6'h01, v); check("R8 flags cleared", v, 0);
  endtask

  initial begin
    int v, nr, flags, mx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NO; k++) begin t0[k] = cyc; rt[k] = 0; end
    // R1 reset state
    rd(6'h00, v); check("R1 busy", v, 0);
    rd(6'h01, v); check("R1 flags", v, 0);
    rd(6'h02, v); check("R1 align", v, 0);
    for (int k = 0; k < NO; k++) begin
      rd(6'(6'h10 + k), v); check("R1 staged", v, 0);
      rd(6'(6'h20 + k), v); check("R1 active", v, 0);
    end
    watch("R1 R2 divide by one", 4);

    wr(6'h02, 4'hF);
    rd(6'h02, v); check("R6 mask readback", v, 15);

    // sweep of ratios, all outputs aligned
    for (int r = 0; r < 8; r++) begin
      flags = 0; mx = 0;
      for (int k = 0; k < NO; k++) begin
        nr = (r * 5 + 3 * k + 1) % 16;
        if (nr != rt[k]) flags |= (1 << k);
        wr(6'(6'h10 + k), nr);
        rd(6'(6'h10 + k), v); check("R3 staged readback", v, nr);
        rd(6'(6'h20 + k), v); check("R3 active unchanged", v, rt[k]);
      end
      rd(6'h01, v); check("R4 flags set", v, flags);
      watch("R3 old periods kept", 3);
      for (int k = 0; k < NO; k++) begin
        rt[k] = (r * 5 + 3 * k + 1) % 16;
        if (rt[k] > mx) mx = rt[k];
      end
      commit_and_wait(15, flags);
      for (int k = 0; k < NO; k++) begin
        rd(6'(6'h20 + k), v); check("R5 active loaded", v, rt[k]);
      end
      watch("R2 new periods", 2 * (mx + 1));
    end

    // R4: write back the running value clears the flag
    wr(6'h10, (rt[0] + 1) % 16);
    rd(6'h01, v); check("R4 flag on differ", v & 1, 1);
    wr(6'h10, rt[0]);
    rd(6'h01, v); check("R4 flag off on equal", v & 1, 0);

    // R7: restart only outputs 0 and 1, outputs 2 and 3 keep phase
    wr(6'h02, 4'h3);
    wr(6'h10, 2); wr(6'h11, 5);
    flags = 0;
    if (rt[0] != 2) flags |= 1;
    if (rt[1] != 5) flags |= 2;
    rt[0] = 2; rt[1] = 5;
    commit_and_wait(3, flags);
    watch("R7 unselected phase kept", 40);

    // R9 R10: commit and ratio write during busy are ignored
    wr(6'h00, 1);
    t0[0] = cyc; t0[1] = cyc;
    begin
      int c_go;
      c_go = cyc;
      wr(6'h00, 1);
      wr(6'h10, 9);
      rd(6'h10, v); check("R10 staged kept", v, rt[0]);
      rd(6'h01, v); check("R10 flag kept", v, 0);
      while (cyc < c_go + BC - 1) tick("R9 pulses during busy");
      rd(6'h00, v); check("R9 busy last cycle", v, 1);
      tick("R9 pulses");
      rd(6'h00, v); check("R9 busy ends on first schedule", v, 0);
      tick("R9 pulses");
      rd(6'h00, v); check("R9 no second busy", v, 0);
    end
    rd(6'h20, v); check("R10 active kept", v, rt[0]);
    watch("R2 final", 12);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule